// File: doc/BRIEF.md
# Clock-Trim Controller Register Block

This block is the software-facing register file of an oscillator trim controller. It gives four 32-bit registers on a simple word bus. The control register holds the counter enable, the auto-trim enable, the trim value, a software sync request and four interrupt enables. The configuration register holds the sync polarity, the sync source, the sync divider, the error limit and the counter reload value. The status register holds the last captured counter value and its direction, plus sticky event flags. The clear register takes write-one-to-clear commands.

The frequency-error counter and the sync path sit outside this block. They reach it through single-cycle event strobes, a capture port and a hardware trim-update port. The block sends back the configuration fields, the enables and a one-cycle software sync pulse. It drives one level interrupt.

Top module: `ctrim_regs`

## Requirements
- R1: After reset, the registers read as follows: control 0x00004000 (trim 64), configuration 0x2022BB7F (polarity 0, source 2, divider 0, limit 0x22, reload 0xBB7F), status 0 and clear 0. The interrupt and the software sync output are both low.
- R2: The control register is at offset 0x0 and uses these bit positions: trim at bits 14:8, auto-trim enable at bit 6, counter enable at bit 5, and interrupt enables at bits 3:0 (bit 3 expected-sync, bit 2 error, bit 1 warning, bit 0 OK). Bits 31:15 and bit 4 read as zero.
- R3: Writing a 1 to control bit 7 makes `swsync_o` high for exactly the one cycle after the write edge. Bit 7 always reads as zero.
- R4: The trim field uses the auto-trim enable as it stood before the write. While that enable is set, software writes leave trim unchanged and `hw_trim_we` loads `hw_trim_val`. While it is clear, software writes load trim and `hw_trim_we` is ignored.
- R5: The configuration register is at offset 0x4 and uses these bit positions: polarity at bit 31, source at bits 29:28, divider at bits 26:24, limit at bits 23:16 and reload at bits 15:0. Bits 30 and 27 read as zero. A write is ignored while the counter enable is set.
- R6: A write takes effect only if all four byte enables are set and address bits 1:0 are zero. Any other write changes nothing.
- R7: The status register is at offset 0x8. Each strobe sets a sticky flag: expected-sync sets bit 3, warning sets bit 1, OK sets bit 0, sync-error sets bit 8, sync-miss sets bit 9 and trim-overflow sets bit 10. Bit 2 reads as the OR of bits 10:8.
- R8: A `cap_valid` pulse stores `cap_count` in status bits 31:16 and `cap_down` in bit 15. Both hold until the next pulse.
- R9: Writing a 1 to a bit of the clear register (offset 0xC) clears the matching flag. Bit 3 clears expected-sync, bit 1 clears warning and bit 0 clears OK. Bit 2 clears all three error flags. The clear register reads as zero.
- R10: If a flag's strobe and its clear come in the same cycle, the flag ends up set.
- R11: `irq_o` is high while any flag has its interrupt enable set. The aggregate error flag counts as one flag. `irq_o` is low while all enables are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables; only 4'hF writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| evt_esync | input | 1 | Counter reached zero strobe |
| evt_ok | input | 1 | Error within small band strobe |
| evt_warn | input | 1 | Error in warning band strobe |
| evt_syncerr | input | 1 | Sync early beyond limit strobe |
| evt_syncmiss | input | 1 | Sync missing beyond limit strobe |
| evt_trimovf | input | 1 | Trim saturated strobe |
| cap_valid | input | 1 | Capture strobe |
| cap_count | input | 16 | Counter value to capture |
| cap_down | input | 1 | Direction to capture (1 = down) |
| hw_trim_we | input | 1 | Hardware trim update strobe |
| hw_trim_val | input | TRIM_W | Hardware trim value |
| cnt_en_o | output | 1 | Counter enable |
| autotrim_o | output | 1 | Auto-trim enable |
| trim_o | output | TRIM_W | Current trim |
| swsync_o | output | 1 | Software sync pulse |
| sync_pol_o | output | 1 | Sync polarity |
| sync_src_o | output | 2 | Sync source select |
| sync_div_o | output | 3 | Sync divider code |
| felim_o | output | 8 | Error limit |
| reload_o | output | 16 | Counter reload value |
| irq_o | output | 1 | Interrupt |

## Verification
The bench targets these corner cases:
- Trim lock on the write that changes auto-trim. A design that uses the new enable value would let the write that turns auto-trim off also overwrite the trim.
- Configuration lock. A design without the lock would change the reload value while the counter runs.
- Partial or misaligned writes. A design that accepts them would corrupt fields.
- Group clear. A one-to-one clear map would leave two error flags set and the error bit still high.
- Same-cycle strobe and clear. A design that lets the clear win would lose an event.
- Interrupt masking. Wrong masking would show up as an interrupt from a disabled flag.

// File: rtl/ctrim_pkg.sv
package ctrim_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned CAP_W    = 16;
    localparam int unsigned FELIM_W  = 8;
    localparam int unsigned RELOAD_W = 16;
    localparam int unsigned IEN_W    = 4;
    localparam int unsigned TRIM_MAX = 7;

    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_CFG  = 4'h4;
    localparam logic [3:0] OFS_STAT = 4'h8;
    localparam logic [3:0] OFS_CLR  = 4'hC;

    localparam logic [WORD_W-1:0] CFG_RST_WORD = 32'h2022_BB7F;

    // control word bit positions
    localparam int unsigned CB_CEN     = 5;
    localparam int unsigned CB_AUTO    = 6;
    localparam int unsigned CB_SWSYNC  = 7;
    localparam int unsigned CB_TRIM_LO = 8;

    // interrupt enable / clear bit positions
    localparam int unsigned IE_OK    = 0;
    localparam int unsigned IE_WARN  = 1;
    localparam int unsigned IE_ERR   = 2;
    localparam int unsigned IE_ESYNC = 3;

    // internal sticky flag indices
    localparam int unsigned FI_OK    = 0;
    localparam int unsigned FI_WARN  = 1;
    localparam int unsigned FI_ESYNC = 2;
    localparam int unsigned FI_SERR  = 3;
    localparam int unsigned FI_SMISS = 4;
    localparam int unsigned FI_TOVF  = 5;
    localparam int unsigned NFLAG    = 6;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_CFG,
        SEL_STAT,
        SEL_CLR
    } reg_sel_e;

    typedef struct packed {
        logic                pol;
        logic [1:0]          src;
        logic [2:0]          div;
        logic [FELIM_W-1:0]  felim;
        logic [RELOAD_W-1:0] reload;
    } cfg_t;

    function automatic cfg_t cfg_unpack(input logic [WORD_W-1:0] w);
        cfg_t c;
        c.pol    = w[31];
        c.src    = w[29:28];
        c.div    = w[26:24];
        c.felim  = w[23:16];
        c.reload = w[15:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_pack(input cfg_t c);
        return {c.pol, 1'b0, c.src, 1'b0, c.div, c.felim, c.reload};
    endfunction

    function automatic logic err_any(input logic [NFLAG-1:0] f);
        return f[FI_SERR] | f[FI_SMISS] | f[FI_TOVF];
    endfunction

    function automatic logic [WORD_W-1:0] stat_pack(
        input logic [CAP_W-1:0] cap,
        input logic             dir,
        input logic [NFLAG-1:0] f
    );
        return {cap, dir, 4'b0000, f[FI_TOVF], f[FI_SMISS], f[FI_SERR],
                4'b0000, f[FI_ESYNC], err_any(f), f[FI_WARN], f[FI_OK]};
    endfunction

endpackage

// File: rtl/ctrim_sticky.sv
module ctrim_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;   // set has priority over clear
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/ctrim_ctrl_reg.sv
module ctrim_ctrl_reg
    import ctrim_pkg::*;
#(
    parameter int unsigned TRIM_W = 7
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [WORD_W-1:0]          wdata,
    input  logic                       hw_trim_we,
    input  logic [TRIM_W-1:0]          hw_trim_val,
    output logic                       cen_q,
    output logic                       auto_q,
    output logic [TRIM_W-1:0]          trim_q,
    output logic                       swsync_q,
    output logic [IEN_W-1:0]           ien_q,
    output logic [WORD_W-1:0]          rd_word
);
    localparam logic [TRIM_W-1:0] TRIM_RST = TRIM_W'(1) << (TRIM_W - 1);

    logic unused_wbits;
    assign unused_wbits = ^{wdata[WORD_W-1:CB_TRIM_LO+TRIM_W], wdata[4]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cen_q    <= 1'b0;
            auto_q   <= 1'b0;
            trim_q   <= TRIM_RST;
            swsync_q <= 1'b0;
            ien_q    <= '0;
        end else begin
            swsync_q <= wr_en & wdata[CB_SWSYNC];
            if (wr_en) begin
                cen_q  <= wdata[CB_CEN];
                auto_q <= wdata[CB_AUTO];
                ien_q  <= wdata[IEN_W-1:0];
            end
            // lock decision uses the enable held before this write
            if (auto_q) begin
                if (hw_trim_we) trim_q <= hw_trim_val;
            end else if (wr_en) begin
                trim_q <= wdata[CB_TRIM_LO +: TRIM_W];
            end
        end
    end

    always_comb begin
        rd_word                           = '0;
        rd_word[CB_TRIM_LO +: TRIM_W]     = trim_q;
        rd_word[CB_AUTO]                  = auto_q;
        rd_word[CB_CEN]                   = cen_q;
        rd_word[IEN_W-1:0]                = ien_q;
    end
endmodule

// File: rtl/ctrim_cfg_reg.sv
module ctrim_cfg_reg
    import ctrim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              lock,
    input  logic [WORD_W-1:0] wdata,
    output cfg_t              cfg_q,
    output logic [WORD_W-1:0] rd_word
);
    localparam cfg_t CFG_RST = cfg_unpack(CFG_RST_WORD);

    logic unused_wbits;
    assign unused_wbits = wdata[30] ^ wdata[27];

    always_ff @(posedge clk) begin
        if (rst)                 cfg_q <= CFG_RST;
        else if (wr_en && !lock) cfg_q <= cfg_unpack(wdata);
    end

    assign rd_word = cfg_pack(cfg_q);
endmodule

// File: rtl/ctrim_status.sv
module ctrim_status
    import ctrim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NFLAG-1:0]  set_vec,
    input  logic [NFLAG-1:0]  clr_vec,
    input  logic              cap_valid,
    input  logic [CAP_W-1:0]  cap_count,
    input  logic              cap_down,
    output logic [NFLAG-1:0]  flag_q,
    output logic [WORD_W-1:0] rd_word
);
    logic [CAP_W-1:0] cap_q;
    logic             dir_q;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        ctrim_sticky u_bit (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_vec[i]),
            .clr_i (clr_vec[i]),
            .q_o   (flag_q[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
            dir_q <= 1'b0;
        end else if (cap_valid) begin
            cap_q <= cap_count;
            dir_q <= cap_down;
        end
    end

    assign rd_word = stat_pack(cap_q, dir_q, flag_q);
endmodule

// File: rtl/ctrim_regs.sv
module ctrim_regs
    import ctrim_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned TRIM_W = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [3:0]          bus_be,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic                evt_esync,
    input  logic                evt_ok,
    input  logic                evt_warn,
    input  logic                evt_syncerr,
    input  logic                evt_syncmiss,
    input  logic                evt_trimovf,
    input  logic                cap_valid,
    input  logic [CAP_W-1:0]    cap_count,
    input  logic                cap_down,
    input  logic                hw_trim_we,
    input  logic [TRIM_W-1:0]   hw_trim_val,
    output logic                cnt_en_o,
    output logic                autotrim_o,
    output logic [TRIM_W-1:0]   trim_o,
    output logic                swsync_o,
    output logic                sync_pol_o,
    output logic [1:0]          sync_src_o,
    output logic [2:0]          sync_div_o,
    output logic [FELIM_W-1:0]  felim_o,
    output logic [RELOAD_W-1:0] reload_o,
    output logic                irq_o
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

    initial begin
        if (TRIM_W < 1 || TRIM_W > TRIM_MAX) $error("TRIM_W out of range");
        if (ADDR_W < 4) $error("ADDR_W too small");
    end

    reg_sel_e          sel;
    logic              full_word;
    logic              wr_ctrl, wr_cfg, wr_clr;
    logic [NFLAG-1:0]  evt_vec, clr_vec, flag_q;
    logic [IEN_W-1:0]  ien_q;
    logic [WORD_W-1:0] ctrl_word, cfg_word, stat_word;
    cfg_t              cfg_q;

    // address decode
    always_comb begin
        unique case (bus_addr)
            A_CTRL:  sel = SEL_CTRL;
            A_CFG:   sel = SEL_CFG;
            A_STAT:  sel = SEL_STAT;
            A_CLR:   sel = SEL_CLR;
            default: sel = SEL_NONE;
        endcase
    end

    assign full_word = bus_sel && bus_we && (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
    assign wr_ctrl   = full_word && (sel == SEL_CTRL);
    assign wr_cfg    = full_word && (sel == SEL_CFG);
    assign wr_clr    = full_word && (sel == SEL_CLR);

    // event strobes and clear map onto internal flag order
    always_comb begin
        evt_vec           = '0;
        evt_vec[FI_OK]    = evt_ok;
        evt_vec[FI_WARN]  = evt_warn;
        evt_vec[FI_ESYNC] = evt_esync;
        evt_vec[FI_SERR]  = evt_syncerr;
        evt_vec[FI_SMISS] = evt_syncmiss;
        evt_vec[FI_TOVF]  = evt_trimovf;

        clr_vec           = '0;
        clr_vec[FI_OK]    = wr_clr & bus_wdata[IE_OK];
        clr_vec[FI_WARN]  = wr_clr & bus_wdata[IE_WARN];
        clr_vec[FI_ESYNC] = wr_clr & bus_wdata[IE_ESYNC];
        clr_vec[FI_SERR]  = wr_clr & bus_wdata[IE_ERR];
        clr_vec[FI_SMISS] = wr_clr & bus_wdata[IE_ERR];
        clr_vec[FI_TOVF]  = wr_clr & bus_wdata[IE_ERR];
    end

    ctrim_ctrl_reg #(.TRIM_W(TRIM_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_ctrl),
        .wdata       (bus_wdata),
        .hw_trim_we  (hw_trim_we),
        .hw_trim_val (hw_trim_val),
        .cen_q       (cnt_en_o),
        .auto_q      (autotrim_o),
        .trim_q      (trim_o),
        .swsync_q    (swsync_o),
        .ien_q       (ien_q),
        .rd_word     (ctrl_word)
    );

    ctrim_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_cfg),
        .lock    (cnt_en_o),
        .wdata   (bus_wdata),
        .cfg_q   (cfg_q),
        .rd_word (cfg_word)
    );

    ctrim_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .set_vec   (evt_vec),
        .clr_vec   (clr_vec),
        .cap_valid (cap_valid),
        .cap_count (cap_count),
        .cap_down  (cap_down),
        .flag_q    (flag_q),
        .rd_word   (stat_word)
    );

    assign sync_pol_o = cfg_q.pol;
    assign sync_src_o = cfg_q.src;
    assign sync_div_o = cfg_q.div;
    assign felim_o    = cfg_q.felim;
    assign reload_o   = cfg_q.reload;

    assign irq_o = (flag_q[FI_ESYNC] & ien_q[IE_ESYNC])
                 | (err_any(flag_q)  & ien_q[IE_ERR])
                 | (flag_q[FI_WARN]  & ien_q[IE_WARN])
                 | (flag_q[FI_OK]    & ien_q[IE_OK]);

    // read mux; clear register reads as zero
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            unique case (sel)
                SEL_CTRL: bus_rdata = ctrl_word;
                SEL_CFG:  bus_rdata = cfg_word;
                SEL_STAT: bus_rdata = stat_word;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ctrim_regs_chk.sv
module ctrim_regs_chk
    import ctrim_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned TRIM_W = 7
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_sel,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [3:0]          bus_be,
    input logic [WORD_W-1:0]   bus_wdata,
    input logic                swsync_o,
    input logic                cnt_en_o,
    input logic                autotrim_o,
    input logic [TRIM_W-1:0]   trim_o,
    input logic                hw_trim_we,
    input logic                sync_pol_o,
    input logic [1:0]          sync_src_o,
    input logic [2:0]          sync_div_o,
    input logic [FELIM_W-1:0]  felim_o,
    input logic [RELOAD_W-1:0] reload_o,
    input logic [NFLAG-1:0]    evt_vec,
    input logic [NFLAG-1:0]    flag_q,
    input logic [IEN_W-1:0]    ien_q,
    input logic                irq_o
);
    logic sw_req;
    assign sw_req = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_CTRL))
                    && (bus_be == 4'hF) && bus_wdata[CB_SWSYNC];

    AST_SWSYNC_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        swsync_o |-> $past(sw_req)); // R3

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        $past(cnt_en_o) |-> $stable({sync_pol_o, sync_src_o, sync_div_o, felim_o, reload_o})); // R5

    AST_TRIM_HELD: assert property (@(posedge clk) disable iff (rst)
        ($past(autotrim_o) && !$past(hw_trim_we)) |-> $stable(trim_o)); // R4

    for (genvar i = 0; i < NFLAG; i++) begin : g_set
        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            $past(evt_vec[i]) |-> flag_q[i]); // R10
    end

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq_o); // R11

    AST_IRQ_ERR: assert property (@(posedge clk) disable iff (rst)
        (ien_q[IE_ERR] && (flag_q[FI_SERR] || flag_q[FI_SMISS] || flag_q[FI_TOVF])) |-> irq_o); // R11
endmodule

bind ctrim_regs ctrim_regs_chk #(.ADDR_W(ADDR_W), .TRIM_W(TRIM_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .swsync_o   (swsync_o),
    .cnt_en_o   (cnt_en_o),
    .autotrim_o (autotrim_o),
    .trim_o     (trim_o),
    .hw_trim_we (hw_trim_we),
    .sync_pol_o (sync_pol_o),
    .sync_src_o (sync_src_o),
    .sync_div_o (sync_div_o),
    .felim_o    (felim_o),
    .reload_o   (reload_o),
    .evt_vec    (evt_vec),
    .flag_q     (flag_q),
    .ien_q      (ien_q),
    .irq_o      (irq_o)
);

// File: tb/ctrim_regs_test.sv
module ctrim_regs_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 0, bus_we = 0;
    logic [3:0]  bus_addr = 0, bus_be = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        evt_esync = 0, evt_ok = 0, evt_warn = 0;
    logic        evt_syncerr = 0, evt_syncmiss = 0, evt_trimovf = 0;
    logic        cap_valid = 0, cap_down = 0;
    logic [15:0] cap_count = 0;
    logic        hw_trim_we = 0;
    logic [6:0]  hw_trim_val = 0;
    logic        cnt_en_o, autotrim_o, swsync_o, sync_pol_o, irq_o;
    logic [6:0]  trim_o;
    logic [1:0]  sync_src_o;
    logic [2:0]  sync_div_o;
    logic [7:0]  felim_o;
    logic [15:0] reload_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctrim_regs uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_esync(evt_esync), .evt_ok(evt_ok), .evt_warn(evt_warn),
        .evt_syncerr(evt_syncerr), .evt_syncmiss(evt_syncmiss), .evt_trimovf(evt_trimovf),
        .cap_valid(cap_valid), .cap_count(cap_count), .cap_down(cap_down),
        .hw_trim_we(hw_trim_we), .hw_trim_val(hw_trim_val),
        .cnt_en_o(cnt_en_o), .autotrim_o(autotrim_o), .trim_o(trim_o), .swsync_o(swsync_o),
        .sync_pol_o(sync_pol_o), .sync_src_o(sync_src_o), .sync_div_o(sync_div_o),
        .felim_o(felim_o), .reload_o(reload_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; bus_be = 0; bus_wdata = 0;
    endtask

    task automatic rdw(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic t_reset;
        rdw(4'h0, rd); check("R1 ctrl", rd, 32'h0000_4000);
        rdw(4'h4, rd); check("R1 cfg", rd, 32'h2022_BB7F);
        rdw(4'h8, rd); check("R1 stat", rd, 32'h0);
        rdw(4'hC, rd); check("R1 clr", rd, 32'h0);
        check("R1 irq/swsync", {30'd0, irq_o, swsync_o}, 32'h0);
        check("R1 reload out", {16'd0, reload_o}, 32'h0000_BB7F);
    endtask

    task automatic t_ctrl;
        wr(4'h0, 32'hFFFF_AA3F);
        rdw(4'h0, rd); check("R2 ctrl fields", rd, 32'h0000_2A2F);
        check("R2 trim out", {25'd0, trim_o}, 32'h2A);
        check("R2 cen out", {31'd0, cnt_en_o}, 32'h1);
    endtask

    task automatic t_cfg;
        wr(4'h4, 32'h1234_5678);               // counter enabled: locked
        rdw(4'h4, rd); check("R5 locked", rd, 32'h2022_BB7F);
        wr(4'h0, 32'h0000_2A00);               // counter off
        wr(4'h4, 32'hB3A5_1234);
        rdw(4'h4, rd); check("R5 cfg write", rd, 32'hB3A5_1234);
        check("R5 cfg outputs", {18'd0, sync_pol_o, sync_src_o, sync_div_o, felim_o},
              {18'd0, 1'b1, 2'd3, 3'd3, 8'hA5});
        wr(4'h4, 32'hFFFF_FFFF);
        rdw(4'h4, rd); check("R5 reserved zero", rd, 32'hB7FF_FFFF);
        wr(4'h4, 32'hB3A5_1234);
    endtask

    task automatic t_word;
        wr(4'h4, 32'h0000_0000, 4'h3);
        rdw(4'h4, rd); check("R6 partial write", rd, 32'hB3A5_1234);
        wr(4'h2, 32'h0000_0500);
        rdw(4'h0, rd); check("R6 misaligned write", rd, 32'h0000_2A00);
    endtask

    task automatic t_swsync;
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = 4'h0; bus_wdata = 32'h0000_2A80; bus_be = 4'hF;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
        check("R3 pulse high", {31'd0, swsync_o}, 32'h1);
        @(negedge clk);
        check("R3 pulse ends", {31'd0, swsync_o}, 32'h0);
        rdw(4'h0, rd); check("R3 reads zero", rd, 32'h0000_2A00);
    endtask

    task automatic t_trim;
        wr(4'h0, 32'h0000_1040);               // auto was off: trim loads
        check("R4 load before lock", {25'd0, trim_o}, 32'h10);
        wr(4'h0, 32'h0000_5540);
        check("R4 sw locked", {25'd0, trim_o}, 32'h10);
        @(negedge clk); hw_trim_we = 1; hw_trim_val = 7'h33;
        @(negedge clk); hw_trim_we = 0;
        rdw(4'h0, rd); check("R4 hw update", rd, 32'h0000_3340);
        wr(4'h0, 32'h0000_0700);               // auto was on: trim kept
        check("R4 lock on disabling write", {25'd0, trim_o}, 32'h33);
        wr(4'h0, 32'h0000_0700);
        check("R4 manual load", {25'd0, trim_o}, 32'h07);
        @(negedge clk); hw_trim_we = 1; hw_trim_val = 7'h44;
        @(negedge clk); hw_trim_we = 0;
        check("R4 hw ignored", {25'd0, trim_o}, 32'h07);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: evt_ok = 1;  1: evt_warn = 1;  2: evt_esync = 1;
            3: evt_syncerr = 1;  4: evt_syncmiss = 1;  default: evt_trimovf = 1;
        endcase
        @(negedge clk);
        {evt_ok, evt_warn, evt_esync, evt_syncerr, evt_syncmiss, evt_trimovf} = '0;
    endtask

    task automatic t_flags;
        pulse(0); rdw(4'h8, rd); check("R7 ok", rd, 32'h001);
        pulse(1); rdw(4'h8, rd); check("R7 warn", rd, 32'h003);
        pulse(2); rdw(4'h8, rd); check("R7 esync", rd, 32'h00B);
        pulse(3); rdw(4'h8, rd); check("R7 syncerr", rd, 32'h10F);
        pulse(4); rdw(4'h8, rd); check("R7 syncmiss", rd, 32'h30F);
        pulse(5); rdw(4'h8, rd); check("R7 trimovf", rd, 32'h70F);
        wr(4'hC, 32'h4); rdw(4'h8, rd); check("R9 group clear", rd, 32'h00B);
        wr(4'hC, 32'h1); rdw(4'h8, rd); check("R9 ok clear", rd, 32'h00A);
        wr(4'hC, 32'hA); rdw(4'h8, rd); check("R9 esync+warn clear", rd, 32'h000);
        pulse(4); rdw(4'h8, rd); check("R7 single error aggregates", rd, 32'h204);
        wr(4'hC, 32'h4); rdw(4'h8, rd); check("R9 error cleared", rd, 32'h000);
        rdw(4'hC, rd); check("R9 clr reads zero", rd, 32'h0);
    endtask

    task automatic t_capture;
        @(negedge clk); cap_valid = 1; cap_count = 16'h1234; cap_down = 1;
        @(negedge clk); cap_valid = 0;
        rdw(4'h8, rd); check("R8 capture down", rd, 32'h1234_8000);
        @(negedge clk); cap_valid = 1; cap_count = 16'hFFFE; cap_down = 0;
        @(negedge clk); cap_valid = 0; cap_count = 16'h5555; cap_down = 1;
        repeat (2) @(negedge clk);
        rdw(4'h8, rd); check("R8 capture held", rd, 32'hFFFE_0000);
    endtask

    task automatic t_setwins;
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = 4'hC; bus_wdata = 32'h5; bus_be = 4'hF;
        evt_ok = 1; evt_syncmiss = 1;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; evt_ok = 0; evt_syncmiss = 0;
        rdw(4'h8, rd); check("R10 set beats clear", rd[15:0], 32'h0205);
        wr(4'hC, 32'hF);
        rdw(4'h8, rd); check("R10 cleared after", rd[15:0], 32'h0);
    endtask

    task automatic t_irq;
        pulse(0);
        @(negedge clk); check("R11 masked", {31'd0, irq_o}, 32'h0);
        wr(4'h0, 32'h0000_4001);
        check("R11 ok enabled", {31'd0, irq_o}, 32'h1);
        wr(4'hC, 32'h1);
        check("R11 ok cleared", {31'd0, irq_o}, 32'h0);
        wr(4'h0, 32'h0000_4004);
        pulse(5);
        check("R11 error via aggregate", {31'd0, irq_o}, 32'h1);
        wr(4'hC, 32'h4);
        check("R11 error cleared", {31'd0, irq_o}, 32'h0);
        wr(4'h0, 32'h0000_4008);
        pulse(1);
        check("R11 warn not enabled", {31'd0, irq_o}, 32'h0);
        pulse(2);
        check("R11 esync enabled", {31'd0, irq_o}, 32'h1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_ctrl();
        t_cfg();
        t_word();
        t_swsync();
        t_trim();
        t_flags();
        t_capture();
        t_setwins();
        t_irq();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule